// File: doc/BRIEF.md
# Slow Crystal Failure Monitor with Real-Time Clock Failover

This block watches the slow external crystal clock while that crystal is feeding the real-time clock. It runs entirely on the slow internal RC clock, which serves as the reference. The crystal is sampled through a synchroniser, and a stall counter measures how long the crystal has gone without a rising edge. If no edge arrives within a parameterised number of reference cycles, the crystal is declared failed. The block then sets a detection flag and, if software has enabled it, raises an interrupt.

Software can also arm an automatic failover. When failover is armed, a failure moves the real-time clock source select from the crystal to the internal RC, and a completion flag is set. The monitor-enable bit and the failover-arm bit can only be set by software. Once set, they stay set until power-on reset.

After a failover, clearing the detection flag does not give the crystal back to the real-time clock. The source stays on the internal RC until software withdraws its crystal request and then asserts it again.

Top module: `slow_xtal_guard`

## Requirements
- R1: Failures are detected only while the monitor-enable bit (csr bit 0) is 1 and the real-time clock source select `rtc_sel` is 1 (crystal). Otherwise a stalled crystal leaves the detection flag at 0.
- R2: A failure is declared when STALL_LIMIT consecutive reference cycles pass without a synchronised rising edge of `xtal_clk`. With the default two-stage synchroniser, the detection flag rises on the (STALL_LIMIT+3)-th `ref_clk` rising edge after a rising edge of `xtal_clk` that is followed by no further rising edge. A crystal waveform whose period is at most STALL_LIMIT reference cycles never fails.
- R3: Monitor enable (csr bit 0) is set by writing 1. Writing 0 has no effect, and only `por_n` clears it.
- R4: Failover arm (csr bit 1) is set by writing 1. Writing 0 has no effect, and only `por_n` clears it.
- R5: The detection flag (csr bit 3) is set on a failure. A write carrying 0 in bit 3 clears it, and a write carrying 1 leaves it unchanged. A failure in the same cycle as a clearing write wins.
- R6: `irq_o` is 1 exactly when the detection flag and the interrupt-enable bit (csr bit 2, read/write) are both 1.
- R7: With failover armed, a failure drives `rtc_sel` to 0 (internal RC) and sets the switch-done flag (csr bit 4), both on the same edge that sets the detection flag.
- R8: After a failover, `rtc_sel` stays 0 even when the detection flag is cleared. It is released only after `rtc_req_xtal` has been 0 for at least one cycle. From then on, `rtc_sel` follows `rtc_req_xtal` again and monitoring resumes.
- R9: With failover not armed, a failure leaves `rtc_sel` unchanged and the switch-done flag at 0.
- R10: After `por_n` every csr bit reads 0, `irq_o` is 0, and `rtc_sel` equals `rtc_req_xtal`.
- R11: The switch-done flag is cleared by a write carrying 0 in bit 4. A write carrying 1 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Slow internal RC clock; clocks the whole monitor |
| por_n | input | 1 | Active-low power-on reset |
| xtal_clk | input | 1 | Slow external crystal clock under watch |
| rtc_req_xtal | input | 1 | Software request: 1 = crystal should feed the real-time clock |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 5 | Write data: bit0 monitor enable, bit1 failover arm, bit2 interrupt enable, bit3 detection flag, bit4 switch done |
| csr_rdata | output | 5 | Control/status register read value, same layout |
| rtc_sel | output | 1 | Real-time clock source select: 1 crystal, 0 internal RC |
| irq_o | output | 1 | Detection interrupt |

## Verification
The assertions check several rules on every cycle:
- the two sticky bits never fall;
- every internal failure event sets the detection flag on the next edge;
- an armed failure moves the source select to the internal RC and sets the done flag;
- the done flag never appears without arming;
- the interrupt agrees with the flag and its enable;
- a forced internal-RC selection holds while the crystal request stays high.

The exact detection threshold and the latency through the synchroniser can only be shown by the bench. It sweeps every high/low crystal waveform around the limit and times a single stall cycle by cycle. The bench also covers the write-one-has-no-effect and write-zero-has-no-effect cases, and the release of the forced selection through the request line.

// File: rtl/sxg_pkg.sv
package sxg_pkg;

  // Control/status register layout
  localparam int CSR_W  = 5;
  localparam int B_MON  = 0;  // monitor enable, set-only
  localparam int B_ARM  = 1;  // failover arm, set-only
  localparam int B_IE   = 2;  // interrupt enable
  localparam int B_DET  = 3;  // failure detected, write 0 to clear
  localparam int B_DONE = 4;  // failover completed, write 0 to clear

  typedef enum logic {
    SRC_RC   = 1'b0,
    SRC_XTAL = 1'b1
  } rtc_src_e;

  // True when the stall counter is one step from the limit.
  function automatic logic stall_at_threshold(logic [31:0] cnt, int unsigned limit);
    return cnt == 32'(limit - 1);
  endfunction

  // Next value of a write-zero-to-clear flag that a hardware event may set.
  function automatic logic w0c_next(logic cur, logic set_evt, logic we, logic wbit);
    if (set_evt)
      return 1'b1;
    else if (we && !wbit)
      return 1'b0;
    else
      return cur;
  endfunction

  // Next value of a bit that software can only set.
  function automatic logic sticky_next(logic cur, logic we, logic wbit);
    return cur | (we & wbit);
  endfunction

endpackage

// File: rtl/sxg_edge_sync.sv
module sxg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 1'b0;
          else        pipe[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 1'b0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  // The last stage only delays, so a rising edge shows as a 1 just ahead of a 0.
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/sxg_stall_counter.sv
module sxg_stall_counter
  import sxg_pkg::*;
#(
  parameter int STALL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic edge_seen,
  output logic fail_evt
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(STALL_LIMIT);

  logic [CNT_W-1:0] cnt;

  assign fail_evt = active && !edge_seen && stall_at_threshold(32'(cnt), STALL_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!active || edge_seen)
      cnt <= '0;
    else if (cnt != CNT_SAT)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sxg_ctl.sv
module sxg_ctl
  import sxg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             fail_evt,
  input  logic             rtc_req_xtal,
  output logic [CSR_W-1:0] csr,
  output logic             forced_rc
);
  logic mon_en, arm, ie, det, done;
  logic failover_evt;

  assign failover_evt = fail_evt & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en    <= 1'b0;
      arm       <= 1'b0;
      ie        <= 1'b0;
      det       <= 1'b0;
      done      <= 1'b0;
      forced_rc <= 1'b0;
    end else begin
      mon_en <= sticky_next(mon_en, we, wdata[B_MON]);
      arm    <= sticky_next(arm, we, wdata[B_ARM]);
      if (we) ie <= wdata[B_IE];
      det    <= w0c_next(det, fail_evt, we, wdata[B_DET]);
      done   <= w0c_next(done, failover_evt, we, wdata[B_DONE]);
      if (failover_evt)
        forced_rc <= 1'b1;
      else if (!rtc_req_xtal)
        forced_rc <= 1'b0;
    end
  end

  always_comb begin
    csr         = '0;
    csr[B_MON]  = mon_en;
    csr[B_ARM]  = arm;
    csr[B_IE]   = ie;
    csr[B_DET]  = det;
    csr[B_DONE] = done;
  end

endmodule

// File: rtl/slow_xtal_guard.sv
module slow_xtal_guard
  import sxg_pkg::*;
#(
  parameter int STALL_LIMIT = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             por_n,
  input  logic             xtal_clk,
  input  logic             rtc_req_xtal,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             rtc_sel,
  output logic             irq_o
);
  // Named internal events, kept visible for the checker
  logic xtal_rise;
  logic mon_active;
  logic fail_evt;
  logic forced_rc;
  rtc_src_e src_now;

  sxg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (ref_clk),
    .rst_n    (por_n),
    .async_in (xtal_clk),
    .rise     (xtal_rise)
  );

  assign src_now    = (rtc_req_xtal && !forced_rc) ? SRC_XTAL : SRC_RC;
  assign mon_active = csr_rdata[B_MON] && (src_now == SRC_XTAL);

  sxg_stall_counter #(.STALL_LIMIT(STALL_LIMIT)) u_cnt (
    .clk       (ref_clk),
    .rst_n     (por_n),
    .active    (mon_active),
    .edge_seen (xtal_rise),
    .fail_evt  (fail_evt)
  );

  sxg_ctl u_ctl (
    .clk          (ref_clk),
    .rst_n        (por_n),
    .we           (csr_we),
    .wdata        (csr_wdata),
    .fail_evt     (fail_evt),
    .rtc_req_xtal (rtc_req_xtal),
    .csr          (csr_rdata),
    .forced_rc    (forced_rc)
  );

  assign rtc_sel = src_now;
  assign irq_o   = csr_rdata[B_DET] & csr_rdata[B_IE];

endmodule

// File: rtl/sxg_checker.sv
module sxg_checker
  import sxg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rtc_req_xtal,
  input logic [CSR_W-1:0] csr_rdata,
  input logic             rtc_sel,
  input logic             irq_o,
  input logic             fail_evt
);

  a_r3_mon_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[B_MON] |=> csr_rdata[B_MON]);

  a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[B_ARM] |=> csr_rdata[B_ARM]);

  a_r1_fail_only_watched: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |-> (csr_rdata[B_MON] && rtc_sel == SRC_XTAL));

  a_r5_fail_sets_det: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> csr_rdata[B_DET]);

  a_r6_irq_needs_det: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (csr_rdata[B_DET] && csr_rdata[B_IE]));

  a_r6_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[B_DET] && csr_rdata[B_IE]) |-> irq_o);

  a_r7_failover: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt && csr_rdata[B_ARM]) |=> (rtc_sel == SRC_RC && csr_rdata[B_DONE]));

  a_r9_done_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[B_DONE] |-> csr_rdata[B_ARM]);

  a_r8_forced_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_sel == SRC_RC && rtc_req_xtal) |=> (rtc_sel == SRC_RC || !rtc_req_xtal));

endmodule

bind slow_xtal_guard sxg_checker u_chk (
  .clk          (ref_clk),
  .rst_n        (por_n),
  .rtc_req_xtal (rtc_req_xtal),
  .csr_rdata    (csr_rdata),
  .rtc_sel      (rtc_sel),
  .irq_o        (irq_o),
  .fail_evt     (fail_evt)
);

// File: tb/slow_xtal_guard_test.sv
`timescale 1ns/1ps
module slow_xtal_guard_test;
  localparam int LIMIT = 8;
  localparam int M_MON = 1, M_ARM = 2, M_IE = 4, M_DET = 8, M_DONE = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       xtal = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [4:0] wdata = '0;
  logic [4:0] rdata;
  logic       rsel;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  slow_xtal_guard #(.STALL_LIMIT(LIMIT), .SYNC_STAGES(2)) uut (
    .ref_clk      (clk),
    .por_n        (por_n),
    .xtal_clk     (xtal),
    .rtc_req_xtal (req),
    .csr_we       (we),
    .csr_wdata    (wdata),
    .csr_rdata    (rdata),
    .rtc_sel      (rsel),
    .irq_o        (irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 1'b0; xtal = 1'b0; req = 1'b0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic csr_write(logic [4:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic wave(int hi, int lo, int periods);
    for (int p = 0; p < periods; p++) begin
      xtal = 1'b1;
      repeat (hi) @(negedge clk);
      xtal = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    // R10: reset state
    do_reset();
    chk("R10 csr", rdata, 0);
    chk("R10 irq", irq, 0);
    chk("R10 sel", rsel, 0);
    req = 1'b1; #1;
    chk("R10 sel follows req", rsel, 1);

    // R2 / R6 / R9: sweep every high/low time around the limit
    for (int a = 1; a <= 5; a++) begin
      for (int b = 1; b <= 5; b++) begin
        int expf;
        do_reset();
        req = 1'b1;
        csr_write(5'(M_MON | M_IE));
        wave(a, b, 6);
        expf = (a + b > LIMIT) ? 1 : 0;
        chk("R2 det vs period", rdata[3], expf);
        chk("R6 irq vs det", irq, expf);
        chk("R9 sel unchanged unarmed", rsel, 1);
        chk("R9 done stays 0", rdata[4], 0);
      end
    end

    // R2: exact latency from the last rising edge; R6 with interrupts disabled
    do_reset();
    req = 1'b1;
    csr_write(5'(M_MON));
    wave(2, 2, 3);
    xtal = 1'b1;
    for (int k = 1; k <= LIMIT + 3; k++) begin
      @(negedge clk);
      if (k == 2) xtal = 1'b0;
      if (k == LIMIT + 2) chk("R2 det not yet", rdata[3], 0);
      if (k == LIMIT + 3) chk("R2 det on time", rdata[3], 1);
    end
    chk("R6 irq masked", irq, 0);

    // R1: no detection while disabled or crystal not selected
    do_reset();
    req = 1'b1;
    repeat (3 * LIMIT) @(negedge clk);
    chk("R1 disabled no det", rdata[3], 0);
    req = 1'b0;
    csr_write(5'(M_MON));
    repeat (3 * LIMIT) @(negedge clk);
    chk("R1 rc source no det", rdata[3], 0);
    req = 1'b1;
    repeat (LIMIT + 4) @(negedge clk);
    chk("R1 watched det", rdata[3], 1);

    // R3 / R4: sticky bits ignore zero writes
    do_reset();
    csr_write(5'(M_MON | M_ARM | M_IE));
    csr_write(5'(0));
    chk("R3 mon kept", rdata[0], 1);
    chk("R4 arm kept", rdata[1], 1);
    chk("R6 ie cleared by write", rdata[2], 0);

    // R5: write 1 leaves flag, write 0 clears it
    do_reset();
    req = 1'b1;
    csr_write(5'(M_MON));
    repeat (LIMIT + 4) @(negedge clk);
    chk("R5 det set", rdata[3], 1);
    req = 1'b0;
    @(negedge clk);
    csr_write(5'(M_MON | M_DET));
    chk("R5 write1 keeps det", rdata[3], 1);
    csr_write(5'(M_MON));
    chk("R5 write0 clears det", rdata[3], 0);

    // R7 / R8 / R11: armed failover
    do_reset();
    req = 1'b1;
    csr_write(5'(M_MON | M_ARM | M_IE));
    wave(2, 2, 3);
    chk("R7 sel before", rsel, 1);
    xtal = 1'b1;
    for (int k = 1; k <= LIMIT + 3; k++) begin
      @(negedge clk);
      if (k == 2) xtal = 1'b0;
      if (k == LIMIT + 2) chk("R7 sel not yet", rsel, 1);
    end
    chk("R7 sel moved to rc", rsel, 0);
    chk("R7 done set", rdata[4], 1);
    chk("R7 det set", rdata[3], 1);
    chk("R6 irq on failover", irq, 1);
    csr_write(5'(M_MON | M_ARM | M_IE | M_DONE));
    chk("R5 det cleared", rdata[3], 0);
    chk("R6 irq cleared", irq, 0);
    chk("R11 done write1 kept", rdata[4], 1);
    chk("R8 sel stays rc", rsel, 0);
    csr_write(5'(M_MON | M_ARM | M_IE));
    chk("R11 done cleared", rdata[4], 0);
    wave(2, 2, 4);
    chk("R8 sel still rc", rsel, 0);
    req = 1'b0;
    @(negedge clk);
    chk("R8 sel with req low", rsel, 0);
    req = 1'b1; #1;
    chk("R8 sel released", rsel, 1);
    wave(3, 3, 5);
    chk("R8 monitor resumes clean", rdata[3], 0);
    chk("R8 sel held", rsel, 1);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule